// File: doc/BRIEF.md
# SPI Memory Status and Write-Protect Controller

This block is the command front end of a small SPI serial memory slave with a 4K x 8 array. It watches the chip-select, serial clock and serial input lines, synchronised into the system clock, and decodes four single-byte commands: read status, write status, set the write latch and clear the write latch. It holds the status byte and drives the serial output for status reads. The status byte carries the protection bits, the write latch and the busy flag.

An external array interface reports each finished byte or page write sequence to the block with the target address. The block grants or refuses that write. A granted write, or an accepted status write, runs an internal write cycle of a fixed number of system clocks. While the cycle runs, every further change is refused. Two controls gate each write. The block-protect field locks an upper part of the array. A hardware lock, built from the protect-enable bit and the active-low protect pin, freezes the protection bits themselves.

Top module: `spi_wp_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x00 and `so_oe`, `busy` and `arr_wr_ok` are 0. The status byte is {WPEN, BP, WEL, WIP} with WPEN cleared, BP=00, the write latch WEL cleared and the busy flag WIP cleared. Serial traffic is ignored until a high-to-low edge of `cs_n` is seen after reset.
- R2: Opcode 0x05 reads status in SPI mode 0: input bits are sampled on rising `sck`, the output changes on falling `sck`, and bytes go MSB first. After the 8 opcode bits, `so` shifts out the live status byte MSB first: bit 7 WPEN, bits 6:4 zero, bit 3 BP1, bit 2 BP0, bit 1 WEL, bit 0 WIP. `so_oe` is 1 only in this data phase.
- R3: A status read during an internal write cycle returns WIP=1.
- R4: Opcode 0x06 sets WEL and opcode 0x04 clears it, whatever the values of WPEN and `wp_n`.
- R5: Opcode 0x01 followed by one data byte writes WPEN from data bit 7 and BP1:BP0 from data bits 3:2, and starts a write cycle. This happens only if WEL=1, no cycle is running, and WPEN=1 with `wp_n`=0 is not the case. A refused status write changes nothing.
- R6: A command only takes effect when `cs_n` rises after exactly 8 `sck` rising edges (16 for a status write). Any other count has no effect.
- R7: Protected addresses: BP=00 protects none, BP=01 protects 0xC00 to 0xFFF, BP=10 protects 0x800 to 0xFFF, BP=11 protects all.
- R8: `arr_wr_ok` shows, one clock after `arr_addr` is applied, whether that address is writable: WEL=1, no cycle running, and the address is not protected.
- R9: A one-clock `arr_commit` pulse on a writable address gives a one-clock `arr_start` pulse in the next clock and starts a write cycle. On any other address it does nothing.
- R10: `busy` (WIP) stays high for exactly WC_CYCLES clocks, and WEL is 0 when the cycle ends.
- R11: While a cycle runs, array commits and status writes are ignored, and the running cycle completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (high-impedance when 0) |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| arr_addr | input | AW | Array address under test or being committed |
| arr_commit | input | 1 | Pulse: a byte/page write sequence has finished |
| arr_wr_ok | output | 1 | Address `arr_addr` is writable now |
| arr_start | output | 1 | Pulse: array write granted, cycle started |
| busy | output | 1 | Internal write cycle running (WIP) |

## Verification
The serial inputs pass three register stages before a command takes effect. The bench therefore waits a full half-bit of 8 clocks after each `sck` or `cs_n` change, and samples `so` just before the next rising `sck`, when the output has long settled. `arr_wr_ok` and `arr_start` are registered one clock behind their inputs. They are sampled 1 ns after that single edge. The busy length is counted clock by clock, from the first high sample to the first low one, and must equal WC_CYCLES. Protection results are swept over every 64-address block edge for all four BP settings. Status-write acceptance is swept over all combinations of WEL, WPEN and `wp_n`.

// File: rtl/swp_pkg.sv
`timescale 1ns/1ps
package swp_pkg;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/swp_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser for N asynchronous pins.
module swp_sync #(
  parameter int N = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic m1, m2;
      always_ff @(posedge clk) begin
        if (rst) begin
          m1 <= RST_VAL[g];
          m2 <= RST_VAL[g];
        end else begin
          m1 <= din[g];
          m2 <= m1;
        end
      end
      assign q[g] = m2;
    end
  endgenerate
endmodule

// File: rtl/swp_frame.sv
`timescale 1ns/1ps
// Serial frame decoder: bit count, opcode capture, status shift-out.
module swp_frame
  import swp_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_s,
  input  logic       sck_s,
  input  logic       si_s,
  input  logic [7:0] status,
  output logic       so,
  output logic       so_oe,
  output logic       ev_wren,
  output logic       ev_wrdi,
  output logic       ev_wrsr,
  output logic       wr_wpen,
  output logic [1:0] wr_bp
);
  localparam int CW = $clog2(FRAME_BITS) + 1;

  logic          cs_p, sck_p;
  logic          active, over;
  logic [CW-1:0] cnt;
  logic [7:0]    sh, op, tx;
  logic          cs_rise, cs_fall, sck_rise, sck_fall, data_phase;

  assign cs_rise    = cs_s & ~cs_p;
  assign cs_fall    = ~cs_s & cs_p;
  assign sck_rise   = sck_s & ~sck_p;
  assign sck_fall   = ~sck_s & sck_p;
  assign data_phase = over || (cnt >= CW'(BYTE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= 1'b0;  sck_p <= 1'b0;
      active <= 1'b0; over <= 1'b0; cnt <= '0;
      sh <= '0; op <= '0; tx <= '0; so_oe <= 1'b0;
      ev_wren <= 1'b0; ev_wrdi <= 1'b0; ev_wrsr <= 1'b0;
      wr_wpen <= 1'b0; wr_bp <= '0;
    end else begin
      cs_p    <= cs_s;
      sck_p   <= sck_s;
      ev_wren <= 1'b0;
      ev_wrdi <= 1'b0;
      ev_wrsr <= 1'b0;
      so_oe   <= active && (op == OP_RDSR) && data_phase;
      if (cs_fall) begin
        active <= 1'b1;
        cnt    <= '0;
        over   <= 1'b0;
        op     <= '0;
      end else if (active && cs_rise) begin
        active  <= 1'b0;
        ev_wren <= (op == OP_WREN) && (cnt == CW'(BYTE_W)) && !over;
        ev_wrdi <= (op == OP_WRDI) && (cnt == CW'(BYTE_W)) && !over;
        ev_wrsr <= (op == OP_WRSR) && (cnt == CW'(2*BYTE_W)) && !over;
        wr_wpen <= sh[7];
        wr_bp   <= sh[3:2];
      end else if (active && sck_rise) begin
        sh  <= {sh[6:0], si_s};
        cnt <= cnt + 1'b1;
        if (&cnt) over <= 1'b1;
        if (cnt == CW'(BYTE_W-1) && !over) op <= {sh[6:0], si_s};
      end
      if (active && sck_fall && (op == OP_RDSR) && data_phase)
        tx <= (cnt[2:0] == 3'd0) ? status : {tx[6:0], 1'b0};
    end
  end

  assign so = tx[7];
endmodule

// File: rtl/swp_prot.sv
`timescale 1ns/1ps
// Block-protect address decode: upper quarter, upper half or whole array.
module swp_prot #(
  parameter int AW = 12
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    bp,
  output logic          prot
);
  always_comb begin
    unique case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = (addr[AW-1:AW-2] == 2'b11);
      2'b10:   prot = addr[AW-1];
      default: prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/swp_wc_timer.sv
`timescale 1ns/1ps
// Internal write-cycle timer: wip high for exactly CYCLES clocks.
module swp_wc_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic wip,
  output logic done
);
  localparam int TW = $clog2(CYCLES + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wip   <= 1'b0;
      cnt_q <= '0;
    end else if (start && !wip) begin
      wip   <= 1'b1;
      cnt_q <= TW'(CYCLES - 1);
    end else if (wip) begin
      if (cnt_q == '0) wip <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = wip && (cnt_q == '0);
endmodule

// File: rtl/spi_wp_ctrl.sv
`timescale 1ns/1ps
// Status register, write latch and write-protect gate of a serial memory slave.
module spi_wp_ctrl
  import swp_pkg::*;
#(
  parameter int AW         = 12,
  parameter int WC_CYCLES  = 5000,
  parameter int FRAME_BITS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  input  logic          wp_n,
  input  logic [AW-1:0] arr_addr,
  input  logic          arr_commit,
  output logic          arr_wr_ok,
  output logic          arr_start,
  output logic          busy
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] pins_s;
  logic             sck_s, cs_s, si_s, wp_s;
  logic             ev_wren, ev_wrdi, ev_wrsr, wr_wpen;
  logic [1:0]       wr_bp;
  logic             wpen_q, wel_q;
  logic [1:0]       bp_q;
  logic             wip, done, prot, hw_lock, start_sr, start_arr;
  logic [7:0]       status;

  swp_sync #(.N(NSYNC), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst(rst), .din({wp_n, si, cs_n, sck}), .q(pins_s)
  );
  assign {wp_s, si_s, cs_s, sck_s} = pins_s;

  assign status = {wpen_q, 3'b000, bp_q, wel_q, wip};

  swp_frame #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sck_s(sck_s), .si_s(si_s),
    .status(status), .so(so), .so_oe(so_oe),
    .ev_wren(ev_wren), .ev_wrdi(ev_wrdi), .ev_wrsr(ev_wrsr),
    .wr_wpen(wr_wpen), .wr_bp(wr_bp)
  );

  swp_prot #(.AW(AW)) u_prot (.addr(arr_addr), .bp(bp_q), .prot(prot));

  assign hw_lock   = wpen_q & ~wp_s;
  assign start_sr  = ev_wrsr & wel_q & ~wip & ~hw_lock;
  assign start_arr = arr_commit & wel_q & ~wip & ~prot;

  swp_wc_timer #(.CYCLES(WC_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start_sr | start_arr), .wip(wip), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wpen_q    <= 1'b0;
      bp_q      <= '0;
      wel_q     <= 1'b0;
      arr_start <= 1'b0;
      arr_wr_ok <= 1'b0;
    end else begin
      if (start_sr) begin
        wpen_q <= wr_wpen;
        bp_q   <= wr_bp;
      end
      if (done)         wel_q <= 1'b0;
      else if (ev_wren) wel_q <= 1'b1;
      else if (ev_wrdi) wel_q <= 1'b0;
      arr_start <= start_arr;
      arr_wr_ok <= wel_q & ~wip & ~prot;
    end
  end

  assign busy = wip;
endmodule

// File: rtl/swp_checker.sv
`timescale 1ns/1ps
module swp_checker (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       so_oe,
  input logic       busy,
  input logic       arr_start,
  input logic       arr_wr_ok,
  input logic       wel,
  input logic [1:0] bp
);
  // R2: output driver off once deselected long enough to pass the pipeline
  a_r2_so_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !so_oe);

  // R9: an array grant opens a fresh cycle
  a_r9_start_opens_cycle: assert property (@(posedge clk) disable iff (rst)
    arr_start |-> (busy && $past(!busy)));

  // R8: writable indication never granted from a busy state
  a_r8_ok_not_from_busy: assert property (@(posedge clk) disable iff (rst)
    arr_wr_ok |-> $past(!busy));

  // R10: write latch is clear when a cycle ends
  a_r10_wel_clear_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  // R5: protection bits move only as a status write cycle begins
  a_r5_bp_moves_with_cycle: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp) |-> (busy && $past(!busy)));
endmodule

bind spi_wp_ctrl swp_checker u_swp_checker (
  .clk(clk), .rst(rst), .cs_n(cs_n), .so_oe(so_oe), .busy(busy),
  .arr_start(arr_start), .arr_wr_ok(arr_wr_ok), .wel(wel_q), .bp(bp_q)
);

// File: tb/spi_wp_ctrl_bench.sv
`timescale 1ns/1ps
module spi_wp_ctrl_bench;
  localparam int AW   = 12;
  localparam int WC   = 800;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst, sck, cs_n, si, wp_n, arr_commit;
  logic [AW-1:0] arr_addr;
  logic so, so_oe, arr_wr_ok, arr_start, busy;

  int n_chk = 0, n_err = 0;
  logic [7:0] s, nv;
  logic ok, got, acc, wp_i, wel_i, wpen_i;
  logic [1:0] bp_i;
  int n;

  always #2.5 clk = ~clk;

  spi_wp_ctrl #(.AW(AW), .WC_CYCLES(WC), .FRAME_BITS(16)) u_spi_wp_ctrl (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .wp_n(wp_n), .arr_addr(arr_addr), .arr_commit(arr_commit),
    .arr_wr_ok(arr_wr_ok), .arr_start(arr_start), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic hp();
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic spi_frame(input logic [31:0] d, input int nb, output logic [7:0] rx, output logic oe_all);
    rx = '0; oe_all = 1'b1;
    cs_n = 1'b0; hp();
    for (int i = 0; i < nb; i++) begin
      si = d[nb-1-i]; hp();
      if (i >= 8 && i < 16) begin
        rx[15-i] = so;
        if (!so_oe) oe_all = 1'b0;
      end
      sck = 1'b1; hp(); sck = 1'b0;
    end
    hp(); cs_n = 1'b1; hp(); hp();
  endtask

  task automatic cmd(input logic [31:0] d, input int nb);
    logic [7:0] r; logic o;
    spi_frame(d, nb, r, o);
  endtask

  task automatic rdsr(output logic [7:0] st, output logic oe_all);
    spi_frame(32'h0500, 16, st, oe_all);
  endtask

  task automatic wrsr(input logic [7:0] v);
    cmd({16'h0, 8'h01, v}, 16);
  endtask

  task automatic wait_idle();
    tick();
    while (busy) tick();
    hp();
  endtask

  task automatic commit(input logic [AW-1:0] a, output logic st);
    arr_addr = a; arr_commit = 1'b1; tick();
    arr_commit = 1'b0; st = arr_start;
  endtask

  function automatic logic prot_of(input int a, input int bp);
    return (bp == 3) || (bp == 2 && a >= 2048) || (bp == 1 && a >= 3072);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; cs_n = 1'b0; sck = 1'b0; si = 1'b0; wp_n = 1'b1;
    arr_commit = 1'b0; arr_addr = '0;
    repeat (5) @(posedge clk); #1;
    rst = 1'b0; tick();
    // R1: reset state
    check("R1 so_oe after reset", so_oe, 0);
    check("R1 busy after reset", busy, 0);
    check("R1 arr_wr_ok after reset", arr_wr_ok, 0);
    // R1: WREN with select already low from reset must be ignored
    cmd(32'h06, 8);
    rdsr(s, ok);
    check("R1 status after reset and unarmed WREN", s, 8'h00);
    check("R2 so_oe during data phase", ok, 1);
    check("R2 so_oe after deselect", so_oe, 0);
    // R4: WREN / WRDI
    cmd(32'h06, 8); rdsr(s, ok);
    check("R4 WREN sets WEL", s, 8'h02);
    // R6: wrong counts
    cmd({16'h0, 8'h01, 8'h0C} >> 1, 15); rdsr(s, ok);
    check("R6 WRSR with 15 clocks", s, 8'h02);
    cmd({15'h0, 8'h01, 8'h0C, 1'b0}, 17); rdsr(s, ok);
    check("R6 WRSR with 17 clocks", s, 8'h02);
    check("R6 no cycle from bad count", busy, 0);
    cmd(32'h04 >> 1, 7); rdsr(s, ok);
    check("R6 WRDI with 7 clocks", s, 8'h02);
    cmd(32'h04, 8); rdsr(s, ok);
    check("R4 WRDI clears WEL", s, 8'h00);
    cmd({23'h0, 8'h06, 1'b0}, 9); rdsr(s, ok);
    check("R6 WREN with 9 clocks", s, 8'h00);

    // R5 / R4 sweep over WEL, WPEN, wp_n and two BP values
    for (int c = 0; c < 16; c++) begin
      wp_i = c[0]; wel_i = c[1]; wpen_i = c[2];
      bp_i = c[3] ? 2'b10 : 2'b01;
      wp_n = 1'b1; hp();
      cmd(32'h06, 8); wrsr({wpen_i, 3'b000, bp_i, 2'b00}); wait_idle();
      rdsr(s, ok);
      check("R5 setup status write", s, {wpen_i, 3'b000, bp_i, 2'b00});
      wp_n = wp_i; hp();
      if (wel_i) begin
        cmd(32'h06, 8); rdsr(s, ok);
        check("R4 WREN under any protect state", s, {wpen_i, 3'b000, bp_i, 2'b10});
      end
      nv  = {~wpen_i, 3'b000, ~bp_i, 2'b00};
      acc = wel_i && !(wpen_i && !wp_i);
      wrsr(nv);
      check("R5 cycle started only when allowed", busy, acc);
      wait_idle(); rdsr(s, ok);
      check("R5 status after write attempt", s,
            acc ? nv : {wpen_i, 3'b000, bp_i, wel_i, 1'b0});
      if (wel_i && !acc) begin
        cmd(32'h04, 8); rdsr(s, ok);
        check("R4 WRDI under hardware lock", s, {wpen_i, 3'b000, bp_i, 2'b00});
      end
    end
    wp_n = 1'b1; hp();

    // R7 / R8: address sweep for each BP value
    for (int b = 0; b < 4; b++) begin
      cmd(32'h06, 8); wrsr({4'h0, 2'(b), 2'b00}); wait_idle();
      cmd(32'h06, 8);
      for (int a = 0; a < 4096; a += 64) begin
        arr_addr = AW'(a); tick();
        check("R7 writable at block start", arr_wr_ok, !prot_of(a, b));
        arr_addr = AW'(a + 63); tick();
        check("R7 writable at block end", arr_wr_ok, !prot_of(a + 63, b));
      end
    end
    cmd(32'h04, 8);
    arr_addr = '0; tick();
    check("R8 no grant without WEL", arr_wr_ok, 0);
    arr_addr = 12'h7FF; tick();
    check("R8 no grant without WEL", arr_wr_ok, 0);

    // R9 / R10: commits with BP=10
    cmd(32'h06, 8); wrsr(8'h08); wait_idle(); cmd(32'h06, 8);
    commit(12'h800, got);
    check("R9 protected commit refused", got, 0);
    check("R9 no cycle on refused commit", busy, 0);
    tick();
    commit(12'h7FF, got);
    check("R9 grant pulse", got, 1);
    n = 1;
    tick();
    check("R9 grant is one clock", arr_start, 0);
    while (busy) begin n++; tick(); end
    check("R10 busy length", n, WC);
    hp(); rdsr(s, ok);
    check("R10 WEL cleared after cycle", s, 8'h08);

    // R3 / R11: activity during a running cycle
    cmd(32'h06, 8); wrsr(8'h04);
    rdsr(s, ok);
    check("R3 status read during cycle", s, 8'h07);
    commit(12'h000, got);
    check("R11 commit ignored while busy", got, 0);
    wrsr(8'h0C);
    check("R11 cycle still running", busy, 1);
    wait_idle(); rdsr(s, ok);
    check("R11 status write ignored while busy", s, 8'h04);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule